// File: doc/BRIEF.md
# Addressable Tap Shift Register

A single-bit serial delay line built from a fixed chain of 32 storage stages. On every active clock edge where the enable is high, the serial input moves into the lowest stage and every other stage passes its bit one position up. A 5-bit tap address selects which stage drives the main output, so the delay from input to output is the address value plus one, anywhere from 1 to 32 edges. The address can change at any time. Moving the tap never discards stored data, because the chain itself always stays 32 stages long.

A second output always presents the top stage, whatever the address. Chaining instances through it gives longer delay lines: the top-stage output of one instance feeds the serial input of the next. The contents at power-up come from a parameter whose bit i is the initial value of stage i. A second parameter picks whether the chain shifts on the rising or the falling clock edge. The block has no reset port, so the initial-contents parameter is the only way to set its starting state.

Top module: `addr_tap_sreg`

## Requirements
- R1: With the tap address held at k and the enable high on every edge, a bit presented at `ser_in` appears on `tap_out` after exactly k+1 active edges.
- R2: Tap address 0 selects stage 0 (one-edge delay), and tap address 31 selects stage 31 (32-edge delay). At address 31, `tap_out` equals `chain_out`.
- R3: `tap_out` is a combinational read of the addressed stage. Changing `tap_sel` changes `tap_out` with no clock edge, and leaves the stored bits untouched.
- R4: On an active edge with `shift_en` high, stage 0 takes `ser_in` and stage i takes the old value of stage i-1, for i from 1 to 31.
- R5: On an active edge with `shift_en` low, every stage keeps its value, and `ser_in` has no effect.
- R6: Before any active edge, stage i holds bit i of parameter `INIT_BITS`, which defaults to all zeros.
- R7: `chain_out` always carries stage 31, independent of `tap_sel`.
- R8: With `ACTIVE_EDGE` set to 1 (falling), the chain shifts only on falling clock edges. With the default value 0 (rising), it shifts only on rising edges.
- R9: Two instances, with the first one's `chain_out` driving the second one's `ser_in`, a shared enable, and the second one's tap at 31, form a 64-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The active edge is chosen by `ACTIVE_EDGE`. |
| shift_en | input | 1 | Active-high shift enable. |
| ser_in | input | 1 | Serial data into stage 0. |
| tap_sel | input | 5 | Tap address. The delay is the value plus one. |
| tap_out | output | 1 | Bit held in the addressed stage. |
| chain_out | output | 1 | Bit held in stage 31, used for cascading. |

## Verification
The bench tracks each instance with a plain 32-bit shift model and compares `tap_out` against it while the data, the enable and the address change at random, including address changes between edges. An inverted index would show up there, as would a mux that wrapped or clipped at the extremes, or an enable that still let data in. Full sweeps over all 32 addresses, at power-up and after idle stretches, catch a reversed `INIT_BITS` mapping, data lost on a tap move, and a registered output that lags one edge behind an address change. A falling-edge instance runs next to a rising-edge one and is checked between the two edges, so a polarity mix-up shows as a half-cycle early or late shift. A single-pulse latency count and a two-instance 64-stage chain pin down off-by-one errors in the delay.

// File: rtl/ats_pkg.sv
package ats_pkg;

    localparam int unsigned ATS_STAGES = 32;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } ats_edge_e;

endpackage

// File: rtl/ats_edge_sel.sv
module ats_edge_sel #(
    parameter ats_pkg::ats_edge_e ACTIVE_EDGE = ats_pkg::EDGE_RISE
) (
    input  logic clk,
    output logic act_clk
);

    // the downstream logic always uses the rising edge of act_clk
    generate
        if (ACTIVE_EDGE == ats_pkg::EDGE_FALL) begin : g_fall
            assign act_clk = ~clk;
        end else begin : g_rise
            assign act_clk = clk;
        end
    endgenerate

endmodule

// File: rtl/ats_chain.sv
module ats_chain #(
    parameter int unsigned          STAGES    = ats_pkg::ATS_STAGES,
    parameter logic [STAGES-1:0]    INIT_BITS = '0
) (
    input  logic              act_clk,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [STAGES-1:0] stages,
    output logic              primed
);

    typedef struct packed {
        logic [STAGES-1:0] bits;
        logic              armed;
    } chain_state_t;

    chain_state_t st_d;
    chain_state_t st_q = '{bits: INIT_BITS, armed: 1'b0};

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        if (shift_en) begin
            st_d.bits = {st_q.bits[STAGES-2:0], ser_in};
        end
    end

    always_ff @(posedge act_clk) begin
        st_q <= st_d;
    end

    assign stages = st_q.bits;
    assign primed = st_q.armed;

    AST_ENTRY_STAGE: assert property (@(posedge act_clk) disable iff (!st_q.armed)
        $past(shift_en) |-> stages[0] == $past(ser_in)); // R4
    AST_STAGES_ADVANCE: assert property (@(posedge act_clk) disable iff (!st_q.armed)
        $past(shift_en) |-> stages[STAGES-1:1] == $past(stages[STAGES-2:0])); // R4
    AST_IDLE_HOLDS: assert property (@(posedge act_clk) disable iff (!st_q.armed)
        !$past(shift_en) |-> $stable(stages)); // R5

endmodule

// File: rtl/ats_tap.sv
module ats_tap #(
    parameter int unsigned STAGES = ats_pkg::ATS_STAGES,
    localparam int unsigned SEL_W = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] stages,
    input  logic [SEL_W-1:0]  tap_sel,
    output logic              tap_out,
    output logic              chain_out
);

    always_comb begin
        tap_out = 1'b0;
        if (32'(tap_sel) < STAGES) begin
            tap_out = stages[tap_sel];
        end
    end

    assign chain_out = stages[STAGES-1];

endmodule

// File: rtl/addr_tap_sreg.sv
module addr_tap_sreg #(
    parameter int unsigned          STAGES      = ats_pkg::ATS_STAGES,
    parameter logic [STAGES-1:0]    INIT_BITS   = '0,
    parameter ats_pkg::ats_edge_e   ACTIVE_EDGE = ats_pkg::EDGE_RISE,
    localparam int unsigned         SEL_W       = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_out,
    output logic             chain_out
);

    logic              act_clk;
    logic [STAGES-1:0] stages;
    logic              primed;

    ats_edge_sel #(.ACTIVE_EDGE(ACTIVE_EDGE)) u_edge (
        .clk     (clk),
        .act_clk (act_clk)
    );

    ats_chain #(.STAGES(STAGES), .INIT_BITS(INIT_BITS)) u_chain (
        .act_clk  (act_clk),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .stages   (stages),
        .primed   (primed)
    );

    ats_tap #(.STAGES(STAGES)) u_tap (
        .stages    (stages),
        .tap_sel   (tap_sel),
        .tap_out   (tap_out),
        .chain_out (chain_out)
    );

    AST_TOP_TAP_IS_CASCADE: assert property (@(posedge act_clk) disable iff (!primed)
        (tap_sel == SEL_W'(STAGES-1)) |-> tap_out == chain_out); // R2
    AST_ZERO_TAP_ONE_EDGE: assert property (@(posedge act_clk) disable iff (!primed)
        ($past(shift_en) && tap_sel == '0) |-> tap_out == $past(ser_in)); // R1
    AST_IDLE_OUTPUT_STEADY: assert property (@(posedge act_clk) disable iff (!primed)
        (!$past(shift_en) && $stable(tap_sel)) |-> $stable(tap_out)); // R5
    AST_CASCADE_IDLE_STEADY: assert property (@(posedge act_clk) disable iff (!primed)
        !$past(shift_en) |-> $stable(chain_out)); // R7

endmodule

// File: tb/tb_addr_tap_sreg.sv
`timescale 1ns/1ps
module tb_addr_tap_sreg;

    localparam logic [31:0] INIT_R = 32'hA5C3_0F96;

    logic       clk = 1'b0;
    logic       en = 1'b0;
    logic       din = 1'b0;
    logic [4:0] tap = 5'd0;
    logic       dout_r, casc_r, dout_f, casc_f;
    logic       c0_casc, c0_dout, c1_dout, c1_casc;
    logic       c1_tap_unused;

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_r = INIT_R;
    logic [31:0] ref_f = '0;
    logic [63:0] ref_c = '0;

    addr_tap_sreg #(.INIT_BITS(INIT_R)) dut (
        .clk(clk), .shift_en(en), .ser_in(din), .tap_sel(tap),
        .tap_out(dout_r), .chain_out(casc_r));

    addr_tap_sreg #(.ACTIVE_EDGE(ats_pkg::EDGE_FALL)) dut_f (
        .clk(clk), .shift_en(en), .ser_in(din), .tap_sel(tap),
        .tap_out(dout_f), .chain_out(casc_f));

    addr_tap_sreg chain0 (
        .clk(clk), .shift_en(en), .ser_in(din), .tap_sel(tap),
        .tap_out(c0_dout), .chain_out(c0_casc));

    addr_tap_sreg chain1 (
        .clk(clk), .shift_en(en), .ser_in(c0_casc), .tap_sel(5'd31),
        .tap_out(c1_dout), .chain_out(c1_casc));

    assign c1_tap_unused = c0_dout ^ c1_casc;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // one 5 ns period: rising edge, check, falling edge, check
    task automatic cycle();
        #0.5 clk = 1'b1;
        if (en) begin
            ref_r = {ref_r[30:0], din};
            ref_c = {ref_c[62:0], din};
        end
        #1.5;
        chk("R1 rising tap", dout_r, ref_r[tap]);
        chk("R7 rising cascade", casc_r, ref_r[31]);
        chk("R8 falling inst idle at rise", dout_f, ref_f[tap]);
        chk("R9 chained 64", c1_dout, ref_c[63]);
        #1.0 clk = 1'b0;
        if (en) ref_f = {ref_f[30:0], din};
        #1.5;
        chk("R8 falling tap", dout_f, ref_f[tap]);
        chk("R7 falling cascade", casc_f, ref_f[31]);
        chk("R8 rising inst idle at fall", dout_r, ref_r[tap]);
        #0.5;
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 32; k++) begin
            tap = 5'(k);
            #0.01;
            chk(req, dout_r, ref_r[k]);
            chk(req, dout_f, ref_f[k]);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #0.2;
        // R6: power-up contents, bit i in stage i
        sweep("R6 init contents");
        chk("R6 init cascade", casc_r, INIT_R[31]);
        chk("R6 default zero cascade", casc_f, 1'b0);

        // R1/R2: single pulse latency at several taps
        foreach (ref_r[i]) begin end
        for (int n = 0; n < 3; n++) begin
            int k;
            int cnt;
            k = (n == 0) ? 0 : (n == 1) ? 31 : 12;
            en = 1'b1; din = 1'b0; tap = 5'(k);
            for (int j = 0; j < 32; j++) cycle();
            din = 1'b1;
            cycle();
            cnt = 1;
            din = 1'b0;
            while (dout_r !== 1'b1 && cnt < 40) begin
                cycle();
                cnt++;
            end
            checks++;
            if (cnt != k + 1) begin
                errors++;
                $display("FAIL R1/R2 latency tap %0d act=%0d exp=%0d", k, cnt, k + 1);
            end
        end
        tap = 5'd31;
        #0.01 chk("R2 top tap equals cascade", dout_r, casc_r);

        // R5: idle with toggling data
        en = 1'b0;
        for (int j = 0; j < 12; j++) begin
            din = j[0];
            cycle();
        end
        sweep("R5 held after idle");

        // R3/R4: random stream with address moves between edges
        for (int j = 0; j < 3000; j++) begin
            din = 1'($urandom);
            en  = ($urandom % 4) != 0;
            tap = 5'($urandom);
            #0.01;
            chk("R3 comb tap move", dout_r, ref_r[tap]);
            cycle();
            if (j % 500 == 499) sweep("R3 sweep midstream");
        end

        // R4: alternating pattern then full sweep
        en = 1'b1;
        for (int j = 0; j < 32; j++) begin
            din = (j % 3) == 0;
            cycle();
        end
        sweep("R4 shifted pattern");
        for (int k = 0; k < 32; k++)
            chk("R4 pattern value", ref_r[k], ((31 - k) % 3) == 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule